// File: doc/BRIEF.md
# PS/2 Pass-Through Host Port

This block connects a processor bus to one PS/2 keyboard or auxiliary device over an open-collector clock and data pair. Frames sent by the device are deserialised and checked for odd parity and framing. The byte is then placed unchanged in a read-only receive buffer. A byte written by the processor is sent to the device as a host-initiated frame with parity appended. No scan-code translation takes place, and no controller command set exists: every byte written goes straight to the device.

Software reads received bytes at offset 0x0 and writes bytes to be sent at the same offset. A read-only status byte sits at offset 0x4. Two level outputs tell the processor when to act. `tx_rdy` is high while the transmit buffer is free. `rx_rdy` is high while an unread byte waits. The line drivers are outside the block: `kbd_clk_oe` and `kbd_dat_oe` high mean "pull the line low", and the inputs return the resolved line levels.

Top module: `ps2_host_port`

## Requirements
- R1: After reset, tx_rdy is 1, rx_rdy is 0, the status byte reads 0x00 and neither line is pulled low.
- R2: A device frame of start bit 0, eight data bits LSB first, an odd-parity bit and stop bit 1 stores the data byte unchanged; offset 0x0 then reads it, status bit 0 is 1 and rx_rdy is 1.
- R3: A write to offset 0x0 while tx_rdy is 1 sets status bit 1, drops tx_rdy, and sends the byte uninterpreted, including values that resemble controller or device commands.
- R4: A transmit holds the clock low for at least HOLD_CYC cycles, then drives data low as start bit and releases the clock. It presents the eight data bits LSB first and then odd parity, each after a device clock falling edge, and releases data for the stop bit. When the device drives data low at the eleventh falling edge, status bit 1 clears and tx_rdy returns to 1.
- R5: A read of offset 0x0 clears status bit 0 and rx_rdy.
- R6: A frame with bad parity or with a start bit of 1 or stop bit of 0 sets status bit 7 and is discarded: the stored byte and rx_rdy are unchanged.
- R7: A valid frame that arrives while status bit 0 is still 1 overwrites the stored byte and sets status bit 6.
- R8: A read of offset 0x4 clears status bits 7 and 6.
- R9: Device clock edges seen while a transmit is in progress are never taken as received data.
- R10: A receive frame with no device clock falling edge for WDOG_CYC cycles is abandoned, and the next falling edge starts a new frame.
- R11: A transmit with no device clock edge for WDOG_CYC cycles after the clock is released ends. Status bit 1 clears, tx_rdy returns to 1 and both lines are released.
- R12: A write to offset 0x0 while status bit 1 is set is ignored and starts no second transfer.
- R13: The clock and data lines are pulled low only while a transmit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset: 0x0 data, 0x4 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from the offset) |
| kbd_clk_i | input | 1 | Resolved PS/2 clock line level |
| kbd_dat_i | input | 1 | Resolved PS/2 data line level |
| kbd_clk_oe | output | 1 | 1 = pull PS/2 clock low |
| kbd_dat_oe | output | 1 | 1 = pull PS/2 data low |
| tx_rdy | output | 1 | Level interrupt: transmit buffer free |
| rx_rdy | output | 1 | Level interrupt: unread received byte |

## Verification
The bench attacks the frame edges. It sends bad parity, a stop bit of 0, and a frame cut off after five bits that has to be abandoned by the receive watchdog. A design that checks even parity or skips the stop check would accept garbage. A receiver without the watchdog would splice the stale bits into the next byte. The bench also sends two bytes back to back without a read to catch a missing overrun flag, and writes during a busy transmit to catch a second, spurious transfer. A device model with no clock catches a transmitter that never frees its buffer. The device model also decodes every host frame bit by bit, so a bit-order, parity or short-hold fault shows up as a wrong byte or a failed hold count.

// File: rtl/ps2_pkg.sv
package ps2_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_HOLD  = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FRAME_LEN = 11;
  localparam int unsigned ST_OBF    = 0;
  localparam int unsigned ST_IBF    = 1;
  localparam int unsigned ST_OVR    = 6;
  localparam int unsigned ST_ERR    = 7;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= lines_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/ps2_rx.sv
module ps2_rx #(
  parameter int unsigned WDOG_CYC = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  output logic       vld,
  output logic       err,
  output logic [7:0] byte_o
);
  localparam int unsigned WDW = $clog2(WDOG_CYC + 1);

  logic [9:0]     sh_q, sh_n;
  logic [3:0]     cnt_q, cnt_n;
  logic [WDW-1:0] wd_q, wd_n;
  logic           vld_q, vld_n, err_q, err_n;
  logic [7:0]     byte_q, byte_n;
  logic [10:0]    frame;

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    wd_n   = wd_q;
    vld_n  = 1'b0;
    err_n  = 1'b0;
    byte_n = byte_q;
    frame  = {dat_lvl, sh_q};
    if (!en) begin
      cnt_n = '0;
      wd_n  = '0;
    end else if (clk_fall) begin
      wd_n = '0;
      if (cnt_q == 4'd10) begin
        cnt_n = '0;
        if (!frame[0] && frame[10] && (^frame[9:1])) begin
          vld_n  = 1'b1;
          byte_n = frame[8:1];
        end else begin
          err_n = 1'b1;
        end
      end else begin
        sh_n  = {dat_lvl, sh_q[9:1]};
        cnt_n = cnt_q + 4'd1;
      end
    end else if (cnt_q != 4'd0) begin
      if (wd_q == WDW'(WDOG_CYC - 1)) begin
        cnt_n = '0;
        wd_n  = '0;
      end else begin
        wd_n = wd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      wd_q   <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      wd_q   <= wd_n;
      vld_q  <= vld_n;
      err_q  <= err_n;
      byte_q <= byte_n;
    end
  end

  assign vld    = vld_q;
  assign err    = err_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/ps2_tx.sv
module ps2_tx
  import ps2_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 20000,
  parameter int unsigned WDOG_CYC = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_i,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  output logic       busy,
  output logic       done,
  output logic       clk_oe,
  output logic       dat_oe
);
  localparam int unsigned MAXC = (HOLD_CYC > WDOG_CYC) ? HOLD_CYC : WDOG_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  tx_state_e     st_q, st_n;
  logic [10:0]   sh_q, sh_n;
  logic [3:0]    cnt_q, cnt_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          done_q, done_n;

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    tmr_n  = tmr_q;
    done_n = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        tmr_n = '0;
        if (start) begin
          st_n = TX_HOLD;
          sh_n = {1'b1, ~^byte_i, byte_i, 1'b0};
        end
      end
      TX_HOLD: begin
        if (tmr_q == TW'(HOLD_CYC - 1)) begin
          st_n  = TX_SHIFT;
          tmr_n = '0;
          cnt_n = '0;
        end else begin
          tmr_n = tmr_q + 1'b1;
        end
      end
      TX_SHIFT: begin
        if (clk_fall) begin
          tmr_n = '0;
          if (cnt_q == 4'd10) begin
            if (!dat_lvl) begin
              st_n   = TX_IDLE;
              done_n = 1'b1;
            end
          end else begin
            sh_n  = {1'b1, sh_q[10:1]};
            cnt_n = cnt_q + 4'd1;
          end
        end else if (tmr_q == TW'(WDOG_CYC - 1)) begin
          st_n   = TX_IDLE;
          done_n = 1'b1;
        end else begin
          tmr_n = tmr_q + 1'b1;
        end
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '1;
      cnt_q  <= '0;
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      tmr_q  <= tmr_n;
      done_q <= done_n;
    end
  end

  assign busy   = (st_q != TX_IDLE);
  assign done   = done_q;
  assign clk_oe = (st_q == TX_HOLD);
  assign dat_oe = (st_q == TX_SHIFT) && !sh_q[0];
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned HOLD_CYC = 20000,
  parameter int unsigned WDOG_CYC = 400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              kbd_clk_i,
  input  logic              kbd_dat_i,
  output logic              kbd_clk_oe,
  output logic              kbd_dat_oe,
  output logic              tx_rdy,
  output logic              rx_rdy
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

  logic       rst_m_q, rst_s_q;
  logic [1:0] lvl, fall;
  logic       rx_vld, rx_err, tx_busy, tx_done;
  logic [7:0] rx_byte;
  logic       rd_out, rd_stat, wr_in, wr_ok;
  logic [7:0] obuf_q, obuf_n, status;
  logic       obf_q, obf_n, ibf_q, ibf_n, ovr_q, ovr_n, perr_q, perr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  ps2_line_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_s_q),
    .lines_i({kbd_dat_i, kbd_clk_i}),
    .lvl_o(lvl), .fall_o(fall)
  );

  ps2_rx #(.WDOG_CYC(WDOG_CYC)) u_rx (
    .clk(clk), .rst_n(rst_s_q), .en(!tx_busy),
    .clk_fall(fall[0]), .dat_lvl(lvl[1]),
    .vld(rx_vld), .err(rx_err), .byte_o(rx_byte)
  );

  ps2_tx #(.HOLD_CYC(HOLD_CYC), .WDOG_CYC(WDOG_CYC)) u_tx (
    .clk(clk), .rst_n(rst_s_q), .start(wr_ok), .byte_i(bus_wdata),
    .clk_fall(fall[0]), .dat_lvl(lvl[1]),
    .busy(tx_busy), .done(tx_done),
    .clk_oe(kbd_clk_oe), .dat_oe(kbd_dat_oe)
  );

  assign rd_out  = bus_cs && !bus_we && (bus_addr == OFS_DATA);
  assign rd_stat = bus_cs && !bus_we && (bus_addr == OFS_STAT);
  assign wr_in   = bus_cs && bus_we && (bus_addr == OFS_DATA);
  assign wr_ok   = wr_in && !ibf_q;

  always_comb begin
    obuf_n = rx_vld ? rx_byte : obuf_q;
    obf_n  = obf_q;
    if (rd_out) obf_n = 1'b0;
    if (rx_vld) obf_n = 1'b1;
    ibf_n = ibf_q;
    if (wr_ok) ibf_n = 1'b1;
    else if (tx_done) ibf_n = 1'b0;
    ovr_n = ovr_q;
    if (rd_stat) ovr_n = 1'b0;
    if (rx_vld && obf_q && !rd_out) ovr_n = 1'b1;
    perr_n = perr_q;
    if (rd_stat) perr_n = 1'b0;
    if (rx_err) perr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      obuf_q <= '0;
      obf_q  <= 1'b0;
      ibf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      obuf_q <= obuf_n;
      obf_q  <= obf_n;
      ibf_q  <= ibf_n;
      ovr_q  <= ovr_n;
      perr_q <= perr_n;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf_q;
    status[ST_IBF] = ibf_q;
    status[ST_OVR] = ovr_q;
    status[ST_ERR] = perr_q;
  end

  assign bus_rdata = (bus_addr == OFS_DATA) ? obuf_q :
                     (bus_addr == OFS_STAT) ? status : 8'h00;
  assign tx_rdy = !ibf_q;
  assign rx_rdy = obf_q;
endmodule

// File: rtl/ps2_host_port_chk.sv
module ps2_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ok,
  input logic       rd_out,
  input logic       rx_vld,
  input logic       rx_err,
  input logic       tx_busy,
  input logic       tx_rdy,
  input logic       rx_rdy,
  input logic       kbd_clk_oe,
  input logic       kbd_dat_oe,
  input logic [7:0] obuf_q
);
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !tx_rdy); // R3
  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out && !rx_vld) |=> !rx_rdy); // R5
  AST_RXRDY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(rx_vld)); // R2
  AST_RX_QUIET_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_busy) && tx_busy) |-> !rx_vld); // R9
  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (!kbd_clk_oe && !kbd_dat_oe)); // R13
  AST_ERR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> $stable(obuf_q)); // R6
endmodule

bind ps2_host_port ps2_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_out(rd_out),
  .rx_vld(rx_vld), .rx_err(rx_err), .tx_busy(tx_busy),
  .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
  .kbd_clk_oe(kbd_clk_oe), .kbd_dat_oe(kbd_dat_oe), .obuf_q(obuf_q)
);

// File: tb/sim_ps2_host_port.sv
`timescale 1ns/1ps
module sim_ps2_host_port;
  localparam int HOLD = 40;
  localparam int WDOG = 2000;
  localparam int H    = 20;

  logic       clk, rst_n;
  logic       bus_cs, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       dev_clk, dev_dat;
  logic       kbd_clk_oe, kbd_dat_oe, tx_rdy, rx_rdy;
  wire        kclk_line = dev_clk & ~kbd_clk_oe;
  wire        kdat_line = dev_dat & ~kbd_dat_oe;

  int total = 0;
  int bad   = 0;
  int hold_run = 0, last_hold = 0, hold_count = 0;

  ps2_host_port #(.ADDR_W(3), .HOLD_CYC(HOLD), .WDOG_CYC(WDOG)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_clk_i(kclk_line), .kbd_dat_i(kdat_line),
    .kbd_clk_oe(kbd_clk_oe), .kbd_dat_oe(kbd_dat_oe),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (kbd_clk_oe) begin
      if (hold_run == 0) hold_count = hold_count + 1;
      hold_run = hold_run + 1;
    end else if (hold_run != 0) begin
      last_hold = hold_run;
      hold_run  = 0;
    end
  end

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

  function automatic logic [7:0] exp_status(input logic obf, input logic ibf,
                                            input logic ovr, input logic err);
    return {err, ovr, 4'b0000, ibf, obf};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 1'b0;
  endtask

  task automatic dev_bits(input logic [10:0] fr, input int n);
    for (int i = 0; i < n; i++) begin
      dev_dat = fr[i];
      repeat (H) @(negedge clk);
      dev_clk = 1'b0;
      repeat (H) @(negedge clk);
      dev_clk = 1'b1;
    end
    repeat (H) @(negedge clk);
    dev_dat = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic dev_send(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    dev_bits({~bad_stop, odd_par(b) ^ bad_par, b, 1'b0}, 11);
  endtask

  task automatic dev_receive(output logic [7:0] b, output logic par, output logic stp,
                             output logic st0);
    wait (kbd_clk_oe == 1'b1);
    wait (kbd_clk_oe == 1'b0);
    repeat (2) @(negedge clk);
    st0 = kdat_line;
    for (int i = 1; i <= 11; i++) begin
      repeat (H) @(negedge clk);
      dev_clk = 1'b0;
      repeat (H) @(negedge clk);
      dev_clk = 1'b1;
      repeat (2) @(negedge clk);
      if (i <= 8) b[i-1] = kdat_line;
      else if (i == 9) par = kdat_line;
      else if (i == 10) begin stp = kdat_line; dev_dat = 1'b0; end
    end
    repeat (H) @(negedge clk);
    dev_dat = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, s, b, prev;
    logic p, stp, st0;
    int hc;
    void'($urandom(32'h5eed1234));
    bus_cs = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    dev_clk = 1; dev_dat = 1;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    check("R1 tx_rdy", tx_rdy, 1);
    check("R1 rx_rdy", rx_rdy, 0);
    check("R1 oe", {kbd_clk_oe, kbd_dat_oe}, 0);
    bus_read(3'd4, s); check("R1 status", s, 0);

    // R2 / R5: random received bytes
    for (int k = 0; k < 8; k++) begin
      b = 8'($urandom);
      dev_send(b, 0, 0);
      check("R2 rx_rdy", rx_rdy, 1);
      bus_read(3'd4, s); check("R2 status", s, exp_status(1, 0, 0, 0));
      bus_read(3'd0, d); check("R2 byte", d, b);
      check("R5 rx_rdy clear", rx_rdy, 0);
      prev = b;
    end

    // R6: parity error, then framing error
    dev_send(8'h3C, 1, 0);
    check("R6 parity rx_rdy", rx_rdy, 0);
    bus_read(3'd0, d); check("R6 buffer kept", d, prev);
    bus_read(3'd4, s); check("R6 status", s, exp_status(0, 0, 0, 1));
    bus_read(3'd4, s); check("R8 cleared", s, 0);
    dev_send(8'hA5, 0, 1);
    check("R6 framing rx_rdy", rx_rdy, 0);
    bus_read(3'd4, s); check("R6 framing status", s, exp_status(0, 0, 0, 1));

    // R7 overrun
    dev_send(8'h11, 0, 0);
    dev_send(8'h22, 0, 0);
    bus_read(3'd4, s); check("R7 status", s, exp_status(1, 0, 1, 0));
    bus_read(3'd0, d); check("R7 newest byte", d, 8'h22);
    bus_read(3'd4, s); check("R8 status cleared", s, 0);

    // R10 receive watchdog
    dev_bits(11'b000_0101_0100, 5);
    repeat (WDOG + 50) @(negedge clk);
    dev_send(8'h5A, 0, 0);
    bus_read(3'd4, s); check("R10 status", s, exp_status(1, 0, 0, 0));
    bus_read(3'd0, d); check("R10 byte", d, 8'h5A);

    // R3 / R4 / R9 / R13: transmit, command-like bytes first
    for (int k = 0; k < 6; k++) begin
      b = (k == 0) ? 8'hFF : (k == 1) ? 8'hED : 8'($urandom);
      bus_write(3'd0, b);
      check("R3 tx_rdy low", tx_rdy, 0);
      bus_read(3'd4, s); check("R3 status", s, exp_status(0, 1, 0, 0));
      dev_receive(d, p, stp, st0);
      check("R3 byte passed", d, b);
      check("R4 start", st0, 0);
      check("R4 parity", p, odd_par(b));
      check("R4 stop", stp, 1);
      check("R4 hold", (last_hold >= HOLD) ? 1 : 0, 1);
      check("R4 tx_rdy back", tx_rdy, 1);
      check("R9 no rx", rx_rdy, 0);
      check("R13 released", {kbd_clk_oe, kbd_dat_oe}, 0);
    end

    // R12 write while busy
    hc = hold_count;
    bus_write(3'd0, 8'h66);
    repeat (3) @(negedge clk);
    bus_write(3'd0, 8'h99);
    dev_receive(d, p, stp, st0);
    check("R12 first byte", d, 8'h66);
    repeat (HOLD * 4) @(negedge clk);
    check("R12 one transfer", hold_count - hc, 1);
    check("R12 tx_rdy", tx_rdy, 1);

    // R11 transmit timeout, device silent
    bus_write(3'd0, 8'h42);
    repeat (HOLD + WDOG + 50) @(negedge clk);
    check("R11 tx_rdy", tx_rdy, 1);
    check("R11 lines", {kbd_clk_oe, kbd_dat_oe}, 0);
    bus_read(3'd4, s); check("R11 status", s, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule